// File: doc/BRIEF.md
# Timer count clock source selector

This block decides when one timer channel's counter advances. It runs on the system clock and gives out a count-enable that is high for exactly one system-clock cycle for each count. A 3-bit source field picks where counts come from. The choices are the system clock itself, a tap of a free-running prescaler (the system clock divided by 4, 16, 64, 256, 1024 or 4096), one of four external clock pins, or the overflow/underflow pulse of a neighbouring channel.

A 2-bit edge field sets whether rising edges, falling edges or both edges of the chosen source produce counts. Counting both edges doubles the count rate. The edge field has no effect in three cases: on the undivided system clock, on the cascade pulse, and while the phase-counting input is high. When the phase-counting input is high the block gives no counts at all, because another decoder drives the counter in that mode.

External pins pass through a synchroniser before edge detection. A change of either field, and reset, reloads the edge history from the present level, so a reconfiguration never creates a count that did not happen. A parameter table maps each code of the source field to a source, so a channel can offer a different set of sources.

Top module: `tmr_clk_select`

## Requirements
- R1: While reset is high, and in the cycle that follows it, `cnt_en` is low.
- R2: With the default table, source codes map as follows: 000 is the system clock, 001 is /4, 010 is /16, 011 is /64, 100 is external pin 0, 101 is external pin 1, 110 is /256 and 111 is the cascade pulse.
- R3: With the undivided system clock selected, `cnt_en` is high in every cycle for every value of the edge field.
- R4: On a prescaler tap of ratio N, edge code 00 (rising) and edge code 01 (falling) each give exactly one count per N cycles.
- R5: Edge codes 10 and 11 (both edges) give two counts per source period on taps and pins, so /4 on both edges runs at the rate of /2.
- R6: An external pin is counted after a 2-flop synchroniser. A pin edge driven between clock edges shows on `cnt_en` after the third following rising clock edge, and the edge field applies to the pin as it does to taps.
- R7: With the cascade source, each one-cycle `casc_pulse` gives one count on the next cycle, for every value of the edge field.
- R8: While `phase_mode` is high, `cnt_en` stays low whatever the source and edge fields hold.
- R9: In the cycle after `sel_src` or `sel_edge` changes, `cnt_en` is low, and the level of the new source at the change is not counted as an edge.
- R10: The parameter `SRC_MAP` (4 bits per code, code i at bits 4i+3..4i) sets the source for each code. It makes /1024, /4096 and external pins 2 and 3 reachable. Source ids: 0 system clock, 1 /4, 2 /16, 3 /64, 4 /256, 5 /1024, 6 /4096, 7-10 external pins 0-3, 11 cascade.
- R11: In a single-edge mode on a tap or a pin, `cnt_en` is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_src | input | 3 | Source code, looked up in `SRC_MAP` |
| sel_edge | input | 2 | 00 rising, 01 falling, 1x both edges |
| phase_mode | input | 1 | Phase-counting mode active; blocks all counts |
| ext_clk | input | N_EXT | Asynchronous external clock pins |
| casc_pulse | input | 1 | Overflow/underflow pulse of the neighbouring channel |
| cnt_en | output | 1 | Registered one-cycle count enable |

## Verification
Latency differs by source. A prescaler tap edge appears on `cnt_en` one clock edge after the divider moves, a cascade pulse one edge after it is driven, and an external pin edge three edges after it is driven. The rate sweeps allow several settling cycles after each change of field before they open a counting window. Each window is a whole multiple of the source period, so the count it expects follows from arithmetic alone and does not depend on phase. The latency checks drive a single pin or cascade edge at a falling clock edge and sample `cnt_en` at the exact falling edge where it is due, and at the ones on either side.

// File: rtl/tcs_pkg.sv
`timescale 1ns/1ps
package tcs_pkg;
  typedef enum logic [3:0] {
    SRC_DIV1    = 4'd0,
    SRC_DIV4    = 4'd1,
    SRC_DIV16   = 4'd2,
    SRC_DIV64   = 4'd3,
    SRC_DIV256  = 4'd4,
    SRC_DIV1024 = 4'd5,
    SRC_DIV4096 = 4'd6,
    SRC_PIN0    = 4'd7,
    SRC_PIN1    = 4'd8,
    SRC_PIN2    = 4'd9,
    SRC_PIN3    = 4'd10,
    SRC_CASC    = 4'd11
  } src_e;

  // number of divided taps (/4 .. /4096)
  localparam int NUM_DIV = 6;
  localparam int MAP_BITS = 4;

  // code i sits at bits [4i +: 4]
  localparam logic [8*MAP_BITS-1:0] DEFAULT_MAP =
    {4'd11, 4'd4, 4'd8, 4'd7, 4'd3, 4'd2, 4'd1, 4'd0};
endpackage

// File: rtl/tcs_prescaler.sv
`timescale 1ns/1ps
module tcs_prescaler #(
  parameter int NUM_DIV = 6
) (
  input  logic               clk,
  input  logic               rst,
  output logic [NUM_DIV-1:0] tap_lvl
);
  localparam int CW = 2 * NUM_DIV;

  logic [CW-1:0] div_q;

  always_ff @(posedge clk) begin
    if (rst) div_q <= '0;
    else     div_q <= div_q + 1'b1;
  end

  // tap k is a square wave with period 4^(k+1)
  for (genvar k = 0; k < NUM_DIV; k++) begin : g_tap
    assign tap_lvl[k] = div_q[2*k+1];
  end
endmodule

// File: rtl/tcs_sync.sv
`timescale 1ns/1ps
module tcs_sync #(
  parameter int N_PINS = 4,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out
);
  for (genvar p = 0; p < N_PINS; p++) begin : g_pin
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '0;
      else     chain <= {chain[STAGES-2:0], pin_in[p]};
    end
    assign pin_out[p] = chain[STAGES-1];
  end
endmodule

// File: rtl/tcs_edge.sv
`timescale 1ns/1ps
module tcs_edge (
  input  logic       clk,
  input  logic       rst,
  input  logic       lvl,
  input  logic       reload,
  input  logic       enable,
  input  logic [1:0] mode,
  input  logic       bypass,
  input  logic       bypass_in,
  output logic       pulse
);
  logic hist;
  logic rise_hit;
  logic fall_hit;
  logic take;

  assign rise_hit = lvl & ~hist;
  assign fall_hit = ~lvl & hist;

  always_comb begin
    if (bypass)       take = bypass_in;
    else if (mode[1]) take = rise_hit | fall_hit;
    else if (mode[0]) take = fall_hit;
    else              take = rise_hit;
  end

  always_ff @(posedge clk) begin
    hist <= lvl;
    if (rst || reload || !enable) pulse <= 1'b0;
    else                          pulse <= take;
  end

  // R11
  single_edge_gap_chk: assert property (@(posedge clk) disable iff (rst)
    (pulse && !mode[1] && !bypass) |=> !pulse);
endmodule

// File: rtl/tmr_clk_select.sv
`timescale 1ns/1ps
module tmr_clk_select
  import tcs_pkg::*;
#(
  parameter int                      N_EXT       = 4,
  parameter int                      SYNC_STAGES = 2,
  parameter logic [8*MAP_BITS-1:0]   SRC_MAP     = DEFAULT_MAP
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [2:0]       sel_src,
  input  logic [1:0]       sel_edge,
  input  logic             phase_mode,
  input  logic [N_EXT-1:0] ext_clk,
  input  logic             casc_pulse,
  output logic             cnt_en
);
  localparam int PIN_BASE = int'(SRC_PIN0);

  logic [NUM_DIV-1:0] tap_lvl;
  logic [N_EXT-1:0]   pin_lvl;
  logic [2:0]         src_q;
  logic [1:0]         edge_q;
  logic               reload;
  src_e               src;
  logic               lvl;
  logic               bypass;
  logic               bypass_in;

  tcs_prescaler #(.NUM_DIV(NUM_DIV)) u_div (
    .clk(clk), .rst(rst), .tap_lvl(tap_lvl));

  tcs_sync #(.N_PINS(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin_in(ext_clk), .pin_out(pin_lvl));

  assign src = src_e'(SRC_MAP[{sel_src, 2'b00} +: MAP_BITS]);

  always_ff @(posedge clk) begin
    src_q  <= sel_src;
    edge_q <= sel_edge;
  end

  assign reload = (sel_src != src_q) || (sel_edge != edge_q);

  always_comb begin
    lvl = 1'b0;
    if (src >= SRC_DIV4 && src <= SRC_DIV4096)
      lvl = tap_lvl[int'(src) - 1];
    else if (src >= SRC_PIN0 && int'(src) < PIN_BASE + N_EXT)
      lvl = pin_lvl[int'(src) - PIN_BASE];
  end

  assign bypass    = (src == SRC_DIV1) || (src == SRC_CASC);
  assign bypass_in = (src == SRC_CASC) ? casc_pulse : 1'b1;

  tcs_edge u_edge (
    .clk(clk), .rst(rst), .lvl(lvl), .reload(reload),
    .enable(!phase_mode), .mode(sel_edge), .bypass(bypass),
    .bypass_in(bypass_in), .pulse(cnt_en));

  // R8
  phase_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    phase_mode |=> !cnt_en);

  // R9
  reload_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (sel_src != $past(sel_src) || sel_edge != $past(sel_edge)) |=> !cnt_en);

  // R3
  full_rate_chk: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_DIV1 && !phase_mode && !reload) |=> cnt_en);

  // R7
  casc_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (src == SRC_CASC && !phase_mode && !reload && casc_pulse) |=> cnt_en);
endmodule

// File: tb/tmr_clk_select_test.sv
`timescale 1ns/1ps
module tmr_clk_select_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] sel_a = 3'd1, sel_b = 3'd1;
  logic [1:0] edge_a = 2'd0, edge_b = 2'd0;
  logic       phase = 1'b0;
  logic [3:0] ext;
  logic       casc;
  logic       en_a, en_b;
  logic [7:0] ph = 8'd0;
  logic       hold = 1'b0;
  logic [3:0] hold_val = 4'd0;
  logic       casc_man = 1'b0;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;
  always @(negedge clk) ph <= ph + 8'd1;

  // pin periods: pin0 16, pin1 32, pin2 8, pin3 64; cascade every 8 cycles
  always_comb ext  = hold ? hold_val : {ph[5], ph[2], ph[4], ph[3]};
  always_comb casc = hold ? casc_man : (ph[2:0] == 3'd0);

  tmr_clk_select uut (
    .clk(clk), .rst(rst), .sel_src(sel_a), .sel_edge(edge_a),
    .phase_mode(phase), .ext_clk(ext), .casc_pulse(casc), .cnt_en(en_a));

  tmr_clk_select #(.SRC_MAP({4'd10, 4'd9, 4'd6, 4'd5, 4'd3, 4'd2, 4'd1, 4'd0})) uut_alt (
    .clk(clk), .rst(rst), .sel_src(sel_b), .sel_edge(edge_b),
    .phase_mode(phase), .ext_clk(ext), .casc_pulse(casc), .cnt_en(en_b));

  function automatic int def_src(input int code);
    case (code)
      0: return 0;  1: return 1;  2: return 2;  3: return 3;
      4: return 7;  5: return 8;  6: return 4;  default: return 11;
    endcase
  endfunction

  function automatic int alt_src(input int code);
    case (code)
      4: return 5;  5: return 6;  6: return 9;  default: return 10;
    endcase
  endfunction

  function automatic int period_of(input int id);
    case (id)
      0: return 1;     1: return 4;     2: return 16;   3: return 64;
      4: return 256;   5: return 1024;  6: return 4096;
      7: return 16;    8: return 32;    9: return 8;    10: return 64;
      default: return 8;
    endcase
  endfunction

  function automatic int expect_cnt(input int id, input int edg, input int w);
    if (id == 0) return w;
    if (id == 11) return w / 8;
    if (edg >= 2) return 2 * (w / period_of(id));
    return w / period_of(id);
  endfunction

  function automatic string tag_of(input int id, input int edg);
    if (id == 0) return "R2 R3";
    if (id == 11) return "R2 R7";
    if (id >= 7) return "R2 R6";
    if (edg >= 2) return "R2 R5";
    return "R2 R4";
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic measure(input bit alt, input int w, output int n);
    n = 0;
    repeat (w) begin
      @(negedge clk);
      if (alt ? en_b : en_a) n++;
    end
  endtask

  initial begin
    #(190000 * 5);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    // R1: quiet while in reset
    repeat (4) begin
      @(negedge clk);
      chk("R1", int'(en_a) + int'(en_b), 0);
    end
    rst = 1'b0;
    @(negedge clk);
    chk("R1", int'(en_a), 0);

    // default table sweep: every code and every edge code
    for (int code = 0; code < 8; code++) begin
      for (int edg = 0; edg < 4; edg++) begin
        @(negedge clk);
        sel_a = 3'(code);
        edge_a = 2'(edg);
        repeat (8) @(negedge clk);
        measure(1'b0, 1024, n);
        chk(tag_of(def_src(code), edg), n, expect_cnt(def_src(code), edg, 1024));
      end
    end

    // R10: remapped table reaches /1024, /4096 and pins 2, 3
    for (int code = 4; code < 8; code++) begin
      for (int edg = 0; edg < 3; edg++) begin
        @(negedge clk);
        sel_b = 3'(code);
        edge_b = 2'(edg);
        repeat (8) @(negedge clk);
        measure(1'b1, 8192, n);
        chk("R10", n, expect_cnt(alt_src(code), edg, 8192));
      end
    end

    // R8: phase mode blocks full-rate and cascade sources
    @(negedge clk);
    phase = 1'b1;
    sel_a = 3'd0;
    repeat (4) @(negedge clk);
    measure(1'b0, 256, n);
    chk("R8", n, 0);
    sel_a = 3'd7;
    repeat (4) @(negedge clk);
    measure(1'b0, 256, n);
    chk("R8", n, 0);
    phase = 1'b0;

    // R9: switching between held pins at different levels gives no count
    hold = 1'b1;
    hold_val = 4'b0001;
    sel_a = 3'd5;
    edge_a = 2'd0;
    repeat (8) @(negedge clk);
    sel_a = 3'd4;
    measure(1'b0, 64, n);
    chk("R9", n, 0);
    edge_a = 2'd1;
    repeat (8) @(negedge clk);
    sel_a = 3'd5;
    measure(1'b0, 64, n);
    chk("R9", n, 0);

    // R6: pin latency of three edges, R11: one cycle wide
    hold_val = 4'b0000;
    sel_a = 3'd4;
    edge_a = 2'd0;
    repeat (8) @(negedge clk);
    hold_val = 4'b0001;
    @(negedge clk); chk("R6", int'(en_a), 0);
    @(negedge clk); chk("R6", int'(en_a), 0);
    @(negedge clk); chk("R6", int'(en_a), 1);
    @(negedge clk); chk("R11", int'(en_a), 0);

    // R7: cascade pulse is counted on the next cycle with edge field ignored
    sel_a = 3'd7;
    edge_a = 2'd1;
    repeat (4) @(negedge clk);
    casc_man = 1'b1;
    @(negedge clk); chk("R7", int'(en_a), 1);
    casc_man = 1'b0;
    @(negedge clk); chk("R7", int'(en_a), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule